// File: doc/BRIEF.md
# Four-Stage Shift/Load Register with J/K-bar Serial Entry

This block is a small register of four stages that share one clock. On each rising clock edge, a mode input picks one of two operations. In load mode, all stages take a parallel word. In shift mode, every stored bit moves one stage toward the last stage. The first stage then takes a value decided by a J input and an inverted-K input. That input pair can set, clear, toggle or hold the first stage.

If the two serial inputs are driven from one signal, the first stage behaves as a plain D flip-flop. The register then works as an ordinary serial-in shifter. A shift in the opposite direction is possible by feeding each stage output back to the parallel input of the stage below it and staying in load mode. An active-low master reset clears every stage at once, without waiting for the clock. A further output always carries the inverse of the last stage.

Top module: `shift_load_reg4`

## Requirements
- R1: With `shift_en` low, a rising edge copies `par_d[i]` into `q[i]` for every stage i.
- R2: With `shift_en` high, a rising edge moves `q[0]`→`q[1]`, `q[1]`→`q[2]` and `q[2]`→`q[3]`.
- R3: With `shift_en` high, the pair (`j_in`, `kb_in`) sets the next `q[0]` as follows: (1,1) gives 1, (0,0) gives 0, (1,0) gives the inverse of the old `q[0]`, and (0,1) keeps the old `q[0]`.
- R4: When `j_in` and `kb_in` carry the same value, a shift loads that value into `q[0]`.
- R5: When `rst_n` goes low, `q` becomes 0000 at once, without a clock edge.
- R6: `q_last_n` is always the inverse of `q[3]`, so it reads 1 during reset.
- R7: While `rst_n` is low, clock edges and all other inputs leave `q` at 0000. After release, the register acts on the first rising edge.
- R8: If each `q[n]` is fed back to `par_d[n-1]`, `par_d[3]` is held at 0 and `shift_en` is held low, the data moves one stage from `q[3]` toward `q[0]` on each edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous master reset, active low |
| shift_en | input | 1 | 1 = shift mode, 0 = parallel load |
| j_in | input | 1 | Serial J input to stage 0 |
| kb_in | input | 1 | Serial inverted-K input to stage 0 |
| par_d | input | 4 | Parallel load word, bit i goes to stage i |
| q | output | 4 | Stage values, bit 0 is the first stage |
| q_last_n | output | 1 | Inverse of the last stage |

## Verification
The clocked properties assume that `shift_en`, `j_in`, `kb_in` and `par_d` are stable around each rising edge. They also assume that `rst_n` changes only between edges, so that a reset never lands on the sampling instant. The bench drives every input, including both edges of `rst_n`, on the falling clock edge. Resets placed in the middle of a sequence are held across at least one rising edge, so the hold-during-reset property is exercised at clock time.

// File: rtl/shift_load_reg4.sv
module shift_load_reg4 #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             j_in,
  input  logic             kb_in,
  input  logic [WIDTH-1:0] par_d,
  output logic [WIDTH-1:0] q,
  output logic             q_last_n
);

  logic             first_nxt;
  logic [WIDTH-1:0] shift_nxt;

  // J sets a cleared stage; inverted K keeps a set stage
  assign first_nxt = (j_in & ~q[0]) | (kb_in & q[0]);
  assign shift_nxt = {q[WIDTH-2:0], first_nxt};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      q <= '0;
    else if (shift_en)
      q <= shift_nxt;
    else
      q <= par_d;
  end

  assign q_last_n = ~q[WIDTH-1];

  a_r1_parallel_load: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> q == $past(par_d));

  a_r2_stages_move: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> q[WIDTH-1:1] == $past(q[WIDTH-2:0]));

  a_r3_set: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en && j_in && kb_in |=> q[0]);

  a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en && !j_in && !kb_in |=> !q[0]);

  a_r3_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en && j_in && !kb_in |=> q[0] != $past(q[0]));

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en && !j_in && kb_in |=> $stable(q[0]));

  a_r7_held_in_reset: assert property (@(posedge clk)
    !rst_n |-> q == '0 && q_last_n);

endmodule

// File: tb/shift_load_reg4_test.sv
module shift_load_reg4_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       shift_en = 1'b0;
  logic       j_in = 1'b0;
  logic       kb_in = 1'b0;
  logic [3:0] par_d = '0;
  logic [3:0] q;
  logic       q_last_n;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  int model [4];

  always #4 clk = ~clk;

  shift_load_reg4 uut (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .j_in(j_in),
    .kb_in(kb_in), .par_d(par_d), .q(q), .q_last_n(q_last_n)
  );

  function automatic logic [3:0] model_word();
    return {model[3][0], model[2][0], model[1][0], model[0][0]};
  endfunction

  task automatic check(string tag, logic [3:0] got, logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic check_outputs(string tag);
    check(tag, q, model_word());
    check("R6", {3'b0, q_last_n}, {3'b0, model[3] == 0});
  endtask

  // inputs applied on a falling edge, model advanced at the rising edge,
  // outputs compared on the next falling edge
  task automatic step(string tag, logic se, logic j, logic kb, logic [3:0] d);
    int old0;
    shift_en = se; j_in = j; kb_in = kb; par_d = d;
    @(posedge clk);
    if (rst_n) begin
      if (!se) begin
        for (int i = 0; i < 4; i++) model[i] = d[i];
      end else begin
        old0 = model[0];
        for (int i = 3; i > 0; i--) model[i] = model[i-1];
        if (j && kb) model[0] = 1;
        else if (!j && !kb) model[0] = 0;
        else if (j) model[0] = 1 - old0;
        else model[0] = old0;
      end
    end
    @(negedge clk);
    check_outputs(tag);
  endtask

  task automatic reset_pulse(int hold_edges);
    rst_n = 1'b0;
    #2;
    for (int i = 0; i < 4; i++) model[i] = 0;
    check_outputs("R5");
    @(negedge clk);
    for (int k = 0; k < hold_edges; k++)
      step("R7", $urandom_range(0, 1), 1'b1, 1'b1, 4'hF);
    rst_n = 1'b1;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got hung expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) model[i] = 0;
    @(negedge clk);
    #1;
    check_outputs("R5");
    @(negedge clk);
    step("R7", 1'b0, 1'b1, 1'b1, 4'hA);
    rst_n = 1'b1;
    step("R7", 1'b0, 1'b0, 1'b0, 4'h9);

    step("R1", 1'b0, 1'b0, 1'b0, 4'h6);
    step("R1", 1'b0, 1'b1, 1'b1, 4'hF);
    step("R1", 1'b0, 1'b0, 1'b1, 4'h0);

    step("R3", 1'b1, 1'b1, 1'b1, 4'hF);
    step("R3", 1'b1, 1'b1, 1'b0, 4'hF);
    step("R3", 1'b1, 1'b1, 1'b0, 4'h0);
    step("R3", 1'b1, 1'b0, 1'b1, 4'h0);
    step("R3", 1'b1, 1'b0, 1'b0, 4'hF);
    step("R2", 1'b1, 1'b0, 1'b1, 4'hF);

    step("R4", 1'b1, 1'b1, 1'b1, 4'h0);
    step("R4", 1'b1, 1'b0, 1'b0, 4'h0);
    step("R4", 1'b1, 1'b1, 1'b1, 4'h0);
    step("R4", 1'b1, 1'b1, 1'b1, 4'h0);

    step("R1", 1'b0, 1'b0, 1'b0, 4'h8);
    for (int k = 0; k < 4; k++)
      step("R8", 1'b0, 1'b0, 1'b0, {1'b0, q[3:1]});
    step("R1", 1'b0, 1'b0, 1'b0, 4'hB);
    for (int k = 0; k < 3; k++)
      step("R8", 1'b0, 1'b0, 1'b0, {1'b0, q[3:1]});

    reset_pulse(2);
    step("R7", 1'b0, 1'b0, 1'b0, 4'h5);

    for (int n = 0; n < 400; n++) begin
      if (n % 97 == 50) reset_pulse($urandom_range(1, 3));
      step("R2", ($urandom_range(0, 3) != 0), $urandom_range(0, 1),
           $urandom_range(0, 1), 4'($urandom_range(0, 15)));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule